// File: doc/BRIEF.md
# Dual-Phase Gray-Code Time Digitizer

This block timestamps the rising edge of an asynchronous discriminator hit and reports how long before a synchronous stop strobe it arrived. Two free-running Gray-coded counters of `CNT_W` bits run from the same clock. One advances on the rising clock edge and the other on the falling edge. The hit is brought into each phase through its own synchroniser. Whichever phase sees the edge first fixes the hit time, so the result resolves half a clock period.

A measurement window opens at reset and after every stop. The first hit edge in a window is kept. Further edges only raise a multi-hit flag. The stop strobe is sampled on the rising edge. On that edge the block registers the interval from hit to stop in half-period units, together with a valid pulse and flags for a missing hit and for extra hits. With a 125 MHz clock, one unit of the interval is 4 ns.

Top module: `tdc_dual_phase`

## Requirements
- R1: Synchronous active-high reset clears `ts_valid`, `ts_interval`, `ts_nohit` and `ts_multi` to 0. It also discards any hit seen before the reset, so a stop after reset with no new hit reports `ts_nohit` = 1.
- R2: Let H be the first clock edge, of either polarity, that samples `hit_async` high. Let S be the rising edge that samples `stop_in` high. Count clock edges of both polarities. When a hit was kept, `ts_interval` = (S − H) − 2·`SYNC_STAGES`, which is 4 half-periods at the default setting.
- R3: Two hits that cross the same rising edge's sampling window half a period apart give intervals that differ by exactly 1. A hit first seen on a falling edge counts as half a period later than one first seen on the rising edge before it.
- R4: Only the first hit edge in a window sets the timestamp. Any later rising edge of `hit_async` in that window leaves `ts_interval` unchanged and sets `ts_multi` = 1 in the result.
- R5: A stop in a window with no hit reports `ts_valid` = 1, `ts_nohit` = 1, `ts_interval` = 0 and `ts_multi` = 0.
- R6: `ts_valid` is high for exactly the one cycle that follows each rising edge that samples `stop_in` high, and low otherwise.
- R7: A hit whose capture edge (H + 2·`SYNC_STAGES` half-periods, rounded up to a rising edge) coincides with the stop edge belongs to the next window. The current window then reports `ts_nohit` = 1, and every stop opens a fresh window.
- R8: Both counters are Gray-coded and change by exactly one bit per step. The interval is computed modulo 2^(`CNT_W`+1), so it stays correct when a counter wraps between hit and stop.
- R9: `ts_interval`, `ts_nohit` and `ts_multi` keep their values between stops, whatever `hit_async` does.
- R10: Only rising edges of `hit_async` count as hits. A hit held high across a stop does not create a hit in the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| hit_async | input | 1 | Discriminator output, asynchronous to `clk` |
| stop_in | input | 1 | Stop strobe, synchronous to the rising edge |
| ts_valid | output | 1 | One-cycle pulse carrying a result |
| ts_interval | output | CNT_W+1 | Hit-to-stop interval in half-period units |
| ts_nohit | output | 1 | Window closed without a hit |
| ts_multi | output | 1 | Window held more than one hit edge |

## Verification
Some behaviours are checked by assertions on every cycle:
- `ts_valid` follows each stop.
- The results hold steady between stops.
- A no-hit result carries a zero interval.
- Each counter steps by a single bit.
- Each synchroniser emits one-cycle edge pulses.
- When both phases report the same hit, the rising-phase count is one ahead of the falling-phase count.

The remaining behaviours depend on where a hit falls relative to the clock, so only the bench scenarios can show them. These are the exact interval values, the half-period step between early and late arrivals, the boundary where a hit is pushed into the next window, the multi-hit flag and the wrap of the counters.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  // Which clock edge a lane of the digitizer runs on.
  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } phase_e;
endpackage

// File: rtl/tdc_gray2bin.sv
`timescale 1ns/1ps
module tdc_gray2bin #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] gray_in,
  output logic [WIDTH-1:0] bin_out
);
  // Each binary bit is the parity of the Gray bits at and above it.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bin_out[i] = ^gray_in[WIDTH-1:i];
  end
endmodule

// File: rtl/tdc_gray_counter.sv
`timescale 1ns/1ps
module tdc_gray_counter
  import tdc_pkg::*;
#(
  parameter int     WIDTH = 12,
  parameter phase_e PHASE = PH_RISE
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] gray_q
);
  logic [WIDTH-1:0] bin_cur;
  logic [WIDTH-1:0] bin_inc;
  logic [WIDTH-1:0] gray_nxt;

  tdc_gray2bin #(.WIDTH(WIDTH)) u_conv (
    .gray_in (gray_q),
    .bin_out (bin_cur)
  );

  always_comb begin
    bin_inc  = bin_cur + WIDTH'(1);
    gray_nxt = bin_inc ^ (bin_inc >> 1);
  end

  if (PHASE == PH_FALL) begin : g_fall
    always_ff @(negedge clk) begin
      if (rst) gray_q <= '0;
      else     gray_q <= gray_nxt;
    end
    AST_GRAY_STEP_FALL: assert property (@(negedge clk) disable iff (rst)
      !rst |=> ($countones(gray_q ^ $past(gray_q)) == 1)); // R8
  end else begin : g_rise
    always_ff @(posedge clk) begin
      if (rst) gray_q <= '0;
      else     gray_q <= gray_nxt;
    end
    AST_GRAY_STEP_RISE: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ($countones(gray_q ^ $past(gray_q)) == 1)); // R8
  end
endmodule

// File: rtl/tdc_edge_sync.sv
`timescale 1ns/1ps
module tdc_edge_sync
  import tdc_pkg::*;
#(
  parameter int     STAGES = 2,
  parameter phase_e PHASE  = PH_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int DEPTH = STAGES + 1;   // synchroniser plus one history flop

  logic [DEPTH-1:0] pipe;
  logic [DEPTH-1:0] pipe_nxt;

  assign pipe_nxt   = {pipe[DEPTH-2:0], async_in};
  assign rise_pulse = pipe[STAGES-1] & ~pipe[STAGES];

  if (PHASE == PH_FALL) begin : g_fall
    always_ff @(negedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= pipe_nxt;
    end
    AST_EDGE_SINGLE_FALL: assert property (@(negedge clk) disable iff (rst)
      rise_pulse |=> !rise_pulse); // R10
  end else begin : g_rise
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= pipe_nxt;
    end
    AST_EDGE_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
      rise_pulse |=> !rise_pulse); // R10
  end
endmodule

// File: rtl/tdc_phase_lane.sv
`timescale 1ns/1ps
module tdc_phase_lane
  import tdc_pkg::*;
#(
  parameter int     CNT_W  = 12,
  parameter int     STAGES = 2,
  parameter phase_e PHASE  = PH_RISE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_async,
  output logic [CNT_W-1:0] count_gray,
  output logic             hit_edge
);
  tdc_gray_counter #(.WIDTH(CNT_W), .PHASE(PHASE)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .gray_q (count_gray)
  );

  tdc_edge_sync #(.STAGES(STAGES), .PHASE(PHASE)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .async_in   (hit_async),
    .rise_pulse (hit_edge)
  );
endmodule

// File: rtl/tdc_dual_phase.sv
`timescale 1ns/1ps
module tdc_dual_phase
  import tdc_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_async,
  input  logic             stop_in,
  output logic             ts_valid,
  output logic [CNT_W:0]   ts_interval,
  output logic             ts_nohit,
  output logic             ts_multi
);
  localparam int STAMP_W = CNT_W + 1;

  // Reset seen by the falling lane, retimed so both lanes leave reset
  // on the same sampled value and stay aligned count for count.
  logic rst_fall;
  always_ff @(posedge clk) rst_fall <= rst;

  logic [CNT_W-1:0] rise_gray, fall_gray;
  logic             rise_edge, fall_edge;

  tdc_phase_lane #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES), .PHASE(PH_RISE)) u_rise (
    .clk        (clk),
    .rst        (rst),
    .hit_async  (hit_async),
    .count_gray (rise_gray),
    .hit_edge   (rise_edge)
  );

  tdc_phase_lane #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES), .PHASE(PH_FALL)) u_fall (
    .clk        (clk),
    .rst        (rst_fall),
    .hit_async  (hit_async),
    .count_gray (fall_gray),
    .hit_edge   (fall_edge)
  );

  // Falling-phase sample, held for half a period so the rising edge sees it.
  logic             fall_seen;
  logic [CNT_W-1:0] fall_snap;
  always_ff @(negedge clk) begin
    if (rst_fall) begin
      fall_seen <= 1'b0;
      fall_snap <= '0;
    end else begin
      fall_seen <= fall_edge;
      if (fall_edge) fall_snap <= fall_gray;
    end
  end

  logic [CNT_W-1:0] rise_bin, fall_bin;
  tdc_gray2bin #(.WIDTH(CNT_W)) u_rise_conv (.gray_in(rise_gray), .bin_out(rise_bin));
  tdc_gray2bin #(.WIDTH(CNT_W)) u_fall_conv (.gray_in(fall_snap), .bin_out(fall_bin));

  // A falling-phase report in the same cycle as the rising detection means
  // the hit was seen half a period earlier.
  logic [STAMP_W-1:0] hit_stamp_now, stop_stamp;
  always_comb begin
    hit_stamp_now = fall_seen ? {fall_bin, 1'b1} : {rise_bin, 1'b0};
    stop_stamp    = {rise_bin, 1'b0};
  end

  logic               got_hit, extra_hit;
  logic [STAMP_W-1:0] hit_stamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_valid    <= 1'b0;
      ts_interval <= '0;
      ts_nohit    <= 1'b0;
      ts_multi    <= 1'b0;
      got_hit     <= 1'b0;
      extra_hit   <= 1'b0;
      hit_stamp_q <= '0;
    end else begin
      ts_valid <= stop_in;
      if (stop_in) begin
        ts_nohit    <= !got_hit;
        ts_multi    <= extra_hit;
        ts_interval <= got_hit ? (stop_stamp - hit_stamp_q) : '0;
        got_hit     <= rise_edge;
        extra_hit   <= 1'b0;
        if (rise_edge) hit_stamp_q <= hit_stamp_now;
      end else if (rise_edge) begin
        if (!got_hit) begin
          got_hit     <= 1'b1;
          hit_stamp_q <= hit_stamp_now;
        end else begin
          extra_hit <= 1'b1;
        end
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!ts_valid && ts_interval == '0 && !ts_nohit && !ts_multi)); // R1
  AST_VALID_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    stop_in |=> ts_valid); // R6
  AST_VALID_ONLY_STOP: assert property (@(posedge clk) disable iff (rst)
    !stop_in |=> !ts_valid); // R6
  AST_NOHIT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ts_valid && ts_nohit) |-> (ts_interval == '0 && !ts_multi)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stop_in |=> $stable({ts_interval, ts_nohit, ts_multi})); // R9
  AST_PHASE_PAIR: assert property (@(posedge clk) disable iff (rst)
    (rise_edge && fall_seen) |-> (rise_bin == fall_bin + CNT_W'(1))); // R3
endmodule

// File: tb/tdc_dual_phase_test.sv
`timescale 1ns/1ps
module tdc_dual_phase_test;
  localparam int CW   = 12;
  localparam int SW   = CW + 1;
  localparam int LAT  = 4;
  localparam int MASK = (1 << SW) - 1;
  localparam int NV   = 6;
  // stimulus vectors: hit phase after a falling edge (ns), idle cycles
  // before stop, second hit present, expected multi flag
  localparam int VEC_PHASE  [NV] = '{1, 3, 5, 7, 3, 1};
  localparam int VEC_GAP    [NV] = '{2, 5, 0, 11, 6, 3};
  localparam int VEC_SECOND [NV] = '{0, 0, 0, 0, 1, 1};
  localparam int VEC_MULTI  [NV] = '{0, 0, 0, 0, 1, 1};

  logic clk = 1'b0, rst = 1'b1, hit = 1'b0, stop = 1'b0;
  logic vld, nohit, multi;
  logic [CW:0] ival;
  int tests = 0, fails = 0, hcnt = 0, first_idx = 0, stop_idx = 0;
  int res_a = 0, res_b = 0, held = 0;

  tdc_dual_phase #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .hit_async(hit), .stop_in(stop),
    .ts_valid(vld), .ts_interval(ival), .ts_nohit(nohit), .ts_multi(multi)
  );

  always #4 clk = ~clk;
  always @(clk) hcnt++;

  function automatic int exp_ival(int s, int f);
    return (s - f - LAT) & MASK;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic raise_hit(int phase);
    @(negedge clk);
    #(phase) hit = 1'b1;
    first_idx = hcnt + 1;
  endtask

  task automatic hit_pulse(int phase);
    raise_hit(phase);
    repeat (3) @(negedge clk);
    #1 hit = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk);
    #1 stop = 1'b1;
    stop_idx = hcnt + 1;
    @(posedge clk);
    #1 stop = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", vld, 0);
    chk("R1 interval after reset", ival, 0);
    chk("R1 nohit after reset", nohit, 0);
    chk("R1 multi after reset", multi, 0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      hit_pulse(VEC_PHASE[v]);
      if (VEC_SECOND[v] != 0) begin
        repeat (2) @(negedge clk);
        #2 hit = 1'b1;
        repeat (3) @(negedge clk);
        #1 hit = 1'b0;
      end
      repeat (VEC_GAP[v]) @(negedge clk);
      do_stop();
      chk("R6 valid on stop", vld, 1);
      chk("R2 nohit clear", nohit, 0);
      chk("R2 R4 interval", ival, exp_ival(stop_idx, first_idx));
      chk("R4 multi flag", multi, VEC_MULTI[v]);
      @(negedge clk);
      chk("R6 valid one cycle", vld, 0);
    end

    // R5: empty window
    do_stop();
    chk("R5 valid", vld, 1);
    chk("R5 nohit", nohit, 1);
    chk("R5 interval zero", ival, 0);
    chk("R5 multi clear", multi, 0);

    // R3: same cycle, early and late half
    hit_pulse(3);
    repeat (4) @(negedge clk);
    do_stop();
    res_a = int'(ival);
    hit_pulse(7);
    repeat (4) @(negedge clk);
    do_stop();
    res_b = int'(ival);
    chk("R3 half-period step", res_a - res_b, 1);

    // R7: capture edge coincides with stop edge
    raise_hit(1);
    @(negedge clk);
    do_stop();
    chk("R7 boundary hit deferred", nohit, 1);
    #1 hit = 1'b0;
    repeat (3) @(negedge clk);
    do_stop();
    chk("R7 deferred hit reported", nohit, 0);
    chk("R7 deferred interval", ival, exp_ival(stop_idx, first_idx));

    // R10: level held across stop is not a new hit
    raise_hit(5);
    repeat (4) @(negedge clk);
    do_stop();
    chk("R10 first window hit", nohit, 0);
    repeat (3) @(negedge clk);
    do_stop();
    chk("R10 held level ignored", nohit, 1);
    #1 hit = 1'b0;

    // R9: results hold while hits arrive without a stop
    hit_pulse(3);
    repeat (2) @(negedge clk);
    do_stop();
    held = int'(ival);
    hit_pulse(5);
    repeat (6) @(negedge clk);
    chk("R9 interval held", ival, held);
    chk("R9 nohit held", nohit, 0);
    chk("R9 valid low between stops", vld, 0);
    do_stop();
    chk("R2 pending hit after hold", ival, exp_ival(stop_idx, first_idx));

    // R8: counters wrap between hit and stop
    hit_pulse(7);
    repeat (4200) @(negedge clk);
    do_stop();
    chk("R8 wrapped interval", ival, exp_ival(stop_idx, first_idx));
    chk("R8 nohit clear", nohit, 0);

    // R1: reset mid-window discards the hit
    hit_pulse(1);
    #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs cleared", ival, 0);
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    do_stop();
    chk("R1 hit discarded", nohit, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule